// File: doc/BRIEF.md
# Programmable Region Decoder with Access-Error Trap

This block sits next to the processor's address bus and classifies every 32-bit access as boot ROM, main RAM, the on-chip register window, or nothing. One region-select line goes high for the target. An access that lands in no region raises an error flag in the same cycle. The flag comes with the faulting address, so the trap logic can record it.

How much ROM and RAM is decoded is not fixed. Two 3-bit size fields in a configuration register set it. The decoded size is a small base doubled once per field step, and it stops growing at the region's ceiling. After reset the decoder claims only 4 KB of ROM and 256 KB of RAM, so boot code must widen the sizes. A control bit turns on write protection for RAM. Once it is on, a RAM write that falls outside both programmed windows is trapped as well. All other word slots in the 256-byte register window are plain scratch storage. They read back what was written and never trap.

Top module: `mem_region_decoder`

## Requirements
- R1: An access at an address below the decoded ROM size asserts `sel_rom` only, with no error.
- R2: With the ROM size field (config word at offset 0x10, bits [2:0]) equal to f, the decoded ROM size is 4096 << f bytes, capped at 512 KB. An access at or above that size, and outside RAM and the window, asserts `acc_err`.
- R3: An access whose offset from 0x02000000 is below the decoded RAM size asserts `sel_ram` only, with no error.
- R4: With the RAM size field (offset 0x10, bits [6:4]) equal to f, the decoded RAM size is 256 KB << f, capped at 4 MB. An access beyond it asserts `acc_err`.
- R5: Any access in 0x01F80000 to 0x01F800FF asserts `sel_reg` and never `acc_err`. A write to any word of the window is stored and read back unchanged on `rd_data`. Address bits [1:0] are ignored.
- R6: An access outside ROM, RAM and the window asserts `acc_err`, with every select low.
- R7: `err_addr` equals `acc_addr` while `acc_err` is high, and is zero otherwise.
- R8: `acc_err` and the selects respond combinationally, in the same cycle as `acc_valid`. A register write takes effect from the next cycle.
- R9: When bit 3 of the word at offset 0x00 is set, a RAM write is trapped unless its 256-byte unit index (offset from 0x02000000, shifted right by 8) lies within [bits 13:0, bits 29:16] of the word at offset 0x20 or of the word at offset 0x24, bounds inclusive. RAM reads are never trapped. With the bit clear, no RAM write is trapped.
- R10: After reset every word of the register window reads zero. As a result, the minimum sizes apply and protection is off.
- R11: At most one select is high. All selects are low when `acc_valid` is low or `acc_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | High for a write access |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Write data for the register window |
| sel_rom | output | 1 | ROM region selected |
| sel_ram | output | 1 | RAM region selected |
| sel_reg | output | 1 | Register window selected |
| acc_err | output | 1 | Memory-exception error for this access |
| err_addr | output | 32 | Faulting address, zero when there is no error |
| rd_data | output | 32 | Register window read data, zero outside the window |

## Verification
The bench builds the block with its default parameters. These are 3-bit size fields with a 4 KB ROM base and a 256 KB RAM base, a 256-byte window of 64 words, and 256-byte protection units. Because the ceilings sit only seven and four steps above the bases, both saturation points can be reached by rewriting the configuration word, and each region's last valid word and first invalid byte can be probed at every size tried. The small unit size puts both window bounds, and the unit just past them, within a few kilobytes of the RAM base, where the reset-size RAM can already reach them.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_RAM  = 2'd2,
    RGN_REG  = 2'd3
  } region_e;

  // Region byte size: base doubled once per field step, clipped at the ceiling.
  function automatic logic [63:0] scaled_size(input int unsigned fld,
                                              input int unsigned lo_log2,
                                              input int unsigned hi_log2);
    int unsigned l;
    l = lo_log2 + fld;
    if (l > hi_log2) l = hi_log2;
    return 64'd1 << l;
  endfunction

  // Window word: low bound in [15:0], high bound in [31:16], each masked to uw bits.
  function automatic logic unit_in_window(input logic [31:0] w,
                                          input logic [15:0] unit,
                                          input int unsigned uw);
    logic [15:0] m;
    m = 16'((32'd1 << uw) - 32'd1);
    return ((w[15:0] & m) <= unit) && (unit <= (w[31:16] & m));
  endfunction

endpackage

// File: rtl/mrd_region.sv
module mrd_region
  import mrd_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          SZ_W         = 3,
  parameter int          ROM_MIN_LOG2 = 12,
  parameter int          ROM_MAX_LOG2 = 19,
  parameter int          RAM_MIN_LOG2 = 18,
  parameter int          RAM_MAX_LOG2 = 22,
  parameter logic [31:0] RAM_BASE     = 32'h0200_0000,
  parameter logic [31:0] REG_BASE     = 32'h01F8_0000,
  parameter int          REG_WIN_LOG2 = 8
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [SZ_W-1:0]         rom_fld,
  input  logic [SZ_W-1:0]         ram_fld,
  output region_e                 region,
  output logic [RAM_MAX_LOG2-1:0] ram_off
);
  localparam int XW = ADDR_W + 1;

  logic [XW-1:0] rom_lim, ram_lim, addr_x, ram_rel;
  logic          rom_hit, ram_hit, reg_hit;

  assign rom_lim = XW'(scaled_size(32'(rom_fld), ROM_MIN_LOG2, ROM_MAX_LOG2));
  assign ram_lim = XW'(scaled_size(32'(ram_fld), RAM_MIN_LOG2, RAM_MAX_LOG2));
  assign addr_x  = {1'b0, addr};
  // Below the base the subtraction borrows into the top bit, so the compare fails.
  assign ram_rel = addr_x - XW'(RAM_BASE);

  assign rom_hit = addr_x < rom_lim;
  assign ram_hit = ram_rel < ram_lim;
  assign reg_hit = addr[ADDR_W-1:REG_WIN_LOG2] == REG_BASE[ADDR_W-1:REG_WIN_LOG2];
  assign ram_off = ram_rel[RAM_MAX_LOG2-1:0];

  always_comb begin
    if (reg_hit)      region = RGN_REG;
    else if (rom_hit) region = RGN_ROM;
    else if (ram_hit) region = RGN_RAM;
    else              region = RGN_NONE;
  end
endmodule

// File: rtl/mrd_regbank.sv
module mrd_regbank #(
  parameter int DATA_W       = 32,
  parameter int REG_WIN_LOG2 = 8,
  parameter int CTRL_IDX     = 0,
  parameter int CFG_IDX      = 4,
  parameter int WIN0_IDX     = 8,
  parameter int WIN1_IDX     = 9,
  localparam int IDX_W       = REG_WIN_LOG2 - 2,
  localparam int WORDS       = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] win0_q,
  output logic [DATA_W-1:0] win1_q
);
  logic [DATA_W-1:0] regs_q [WORDS];

  // Every slot is storage; only a few of them also feed the decoder.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_idx];
  assign ctrl_q  = regs_q[CTRL_IDX];
  assign cfg_q   = regs_q[CFG_IDX];
  assign win0_q  = regs_q[WIN0_IDX];
  assign win1_q  = regs_q[WIN1_IDX];

  // R5: a write lands in its slot by the next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/mrd_prot.sv
module mrd_prot #(
  parameter int  RAM_MAX_LOG2 = 22,
  parameter int  UNIT_LOG2    = 8,
  parameter int  NWIN         = 2,
  localparam int UNIT_W       = RAM_MAX_LOG2 - UNIT_LOG2
) (
  input  logic                     enable,
  input  logic                     is_ram,
  input  logic                     is_write,
  input  logic [RAM_MAX_LOG2-1:0]  ram_off,
  input  logic [NWIN-1:0][31:0]    win_words,
  output logic                     fault
);
  logic [UNIT_W-1:0] unit;
  logic [NWIN-1:0]   hit;

  assign unit = ram_off[RAM_MAX_LOG2-1:UNIT_LOG2];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit[g] = mrd_pkg::unit_in_window(win_words[g], 16'(unit), UNIT_W);
  end

  assign fault = enable && is_ram && is_write && (hit == '0);
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 32,
  parameter int          SZ_W         = 3,
  parameter int          ROM_MIN_LOG2 = 12,
  parameter int          ROM_MAX_LOG2 = 19,
  parameter int          RAM_MIN_LOG2 = 18,
  parameter int          RAM_MAX_LOG2 = 22,
  parameter logic [31:0] RAM_BASE     = 32'h0200_0000,
  parameter logic [31:0] REG_BASE     = 32'h01F8_0000,
  parameter int          REG_WIN_LOG2 = 8,
  parameter int          UNIT_LOG2    = 8,
  parameter int          ROM_FLD_LSB  = 0,
  parameter int          RAM_FLD_LSB  = 4,
  parameter int          PROT_BIT     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              sel_rom,
  output logic              sel_ram,
  output logic              sel_reg,
  output logic              acc_err,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = REG_WIN_LOG2 - 2;
  localparam logic [ADDR_W:0] TOP_END = (ADDR_W+1)'(RAM_BASE) + ((ADDR_W+1)'(1) << RAM_MAX_LOG2);

  region_e                 region;
  logic [RAM_MAX_LOG2-1:0] ram_off;
  logic [DATA_W-1:0]       ctrl_q, cfg_q, win0_q, win1_q, bank_rd;
  logic [IDX_W-1:0]        word_idx;
  logic                    prot_fault, bad_region, reg_wr;

  assign word_idx = acc_addr[REG_WIN_LOG2-1:2];

  mrd_region #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W),
    .ROM_MIN_LOG2(ROM_MIN_LOG2), .ROM_MAX_LOG2(ROM_MAX_LOG2),
    .RAM_MIN_LOG2(RAM_MIN_LOG2), .RAM_MAX_LOG2(RAM_MAX_LOG2),
    .RAM_BASE(RAM_BASE), .REG_BASE(REG_BASE), .REG_WIN_LOG2(REG_WIN_LOG2)
  ) u_region (
    .addr    (acc_addr),
    .rom_fld (cfg_q[ROM_FLD_LSB +: SZ_W]),
    .ram_fld (cfg_q[RAM_FLD_LSB +: SZ_W]),
    .region  (region),
    .ram_off (ram_off)
  );

  mrd_regbank #(
    .DATA_W(DATA_W), .REG_WIN_LOG2(REG_WIN_LOG2),
    .CTRL_IDX(0), .CFG_IDX(4), .WIN0_IDX(8), .WIN1_IDX(9)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (word_idx),
    .wr_data (acc_wdata),
    .rd_idx  (word_idx),
    .rd_data (bank_rd),
    .ctrl_q  (ctrl_q),
    .cfg_q   (cfg_q),
    .win0_q  (win0_q),
    .win1_q  (win1_q)
  );

  mrd_prot #(
    .RAM_MAX_LOG2(RAM_MAX_LOG2), .UNIT_LOG2(UNIT_LOG2), .NWIN(2)
  ) u_prot (
    .enable    (ctrl_q[PROT_BIT]),
    .is_ram    (region == RGN_RAM),
    .is_write  (acc_write),
    .ram_off   (ram_off),
    .win_words ({32'(win1_q), 32'(win0_q)}),
    .fault     (prot_fault)
  );

  assign bad_region = (region == RGN_NONE);
  assign acc_err    = acc_valid && (bad_region || prot_fault);
  assign err_addr   = acc_err ? acc_addr : '0;
  assign sel_rom    = acc_valid && !acc_err && (region == RGN_ROM);
  assign sel_ram    = acc_valid && !acc_err && (region == RGN_RAM);
  assign sel_reg    = acc_valid && (region == RGN_REG);
  assign reg_wr     = sel_reg && acc_write;
  assign rd_data    = sel_reg ? bank_rd : '0;

  // R11: selects are mutually exclusive and silent on error
  a_r11_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom, sel_ram, sel_reg}) && !(acc_err && (sel_rom || sel_ram || sel_reg)));
  // R5: the register window never traps
  a_r5_win_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[ADDR_W-1:REG_WIN_LOG2] == REG_BASE[ADDR_W-1:REG_WIN_LOG2]) |-> !acc_err);
  // R7: faulting address is reported only with the flag
  a_r7_err_addr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err ? (err_addr == acc_addr) : (err_addr == '0));
  // R9: reads are never trapped by protection
  a_r9_read_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |-> !prot_fault);
  // R6: anything past the RAM ceiling always traps
  a_r6_high_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && {1'b0, acc_addr} >= TOP_END) |-> acc_err);
endmodule

// File: tb/mem_region_decoder_tb.sv
module mem_region_decoder_tb;
  typedef struct {
    logic        rom, ram, rg, err;
    logic [31:0] eaddr, rdata;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, acc_valid = 0, acc_write = 0;
  logic [31:0] acc_addr = 0, acc_wdata = 0;
  logic        sel_rom, sel_ram, sel_reg, acc_err;
  logic [31:0] err_addr, rd_data;
  int          checks = 0, failures = 0;
  bit          done = 0;
  exp_t        q[$];
  logic [31:0] m_regs [64];

  always #5 clk = ~clk;

  mem_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sel_rom(sel_rom), .sel_ram(sel_ram),
    .sel_reg(sel_reg), .acc_err(acc_err), .err_addr(err_addr), .rd_data(rd_data));

  function automatic logic in_win(input logic [31:0] w, input logic [31:0] u);
    return (u >= {18'd0, w[13:0]}) && (u <= {18'd0, w[29:16]});
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic w, input string tag);
    exp_t e;
    logic [31:0] romlim, ramlim, rel;
    int rf, mf;
    rf = int'(m_regs[4][2:0]);
    mf = int'(m_regs[4][6:4]);
    romlim = (rf >= 7) ? 32'h0008_0000 : (32'h1000 << rf);
    ramlim = (mf >= 4) ? 32'h0040_0000 : (32'h0004_0000 << mf);
    rel = a - 32'h0200_0000;
    e = '{rom: 0, ram: 0, rg: 0, err: 0, eaddr: 0, rdata: 0, tag: tag};
    if (a[31:8] == 24'h01F800) begin
      e.rg = 1; e.rdata = m_regs[a[7:2]];
    end else if (a < romlim) e.rom = 1;
    else if (a >= 32'h0200_0000 && rel < ramlim) begin
      if (w && m_regs[0][3] && !in_win(m_regs[8], rel >> 8) && !in_win(m_regs[9], rel >> 8))
        e.err = 1;
      else e.ram = 1;
    end else e.err = 1;
    if (e.err) e.eaddr = a;
    return e;
  endfunction

  task automatic drv(input logic [31:0] a, input logic w, input logic [31:0] d, input string tag);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d;
    q.push_back(model(a, w, tag));
    if (w && a[31:8] == 24'h01F800) m_regs[a[7:2]] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  // Monitor: compare each strobed access 1 ns before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (acc_valid) begin
        if (q.size() == 0) begin
          failures++; checks++;
          $display("FAIL monitor: output with empty queue addr=%h expected no access", acc_addr);
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if ({sel_rom, sel_ram, sel_reg, acc_err} !== {e.rom, e.ram, e.rg, e.err} ||
              err_addr !== e.eaddr || rd_data !== e.rdata) begin
            failures++;
            $display("FAIL %s addr=%h: got sel=%b%b%b err=%b ea=%h rd=%h, expected sel=%b%b%b err=%b ea=%h rd=%h",
              e.tag, acc_addr, sel_rom, sel_ram, sel_reg, acc_err, err_addr, rd_data,
              e.rom, e.ram, e.rg, e.err, e.eaddr, e.rdata);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog: run not finished, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset contents
    drv(32'h01F8_0010, 0, 0, "R10 cfg reset");
    drv(32'h01F8_0000, 0, 0, "R10 ctrl reset");
    drv(32'h01F8_0020, 0, 0, "R10 win reset");
    // R1/R2 at reset size (4 KB)
    drv(32'h0000_0000, 0, 0, "R1 rom base");
    drv(32'h0000_0FFC, 0, 0, "R1 rom last");
    drv(32'h0000_1000, 0, 0, "R2 rom past reset size");
    // R3/R4 at reset size (256 KB)
    drv(32'h0200_0000, 1, 0, "R3 ram base");
    drv(32'h0203_FFFC, 0, 0, "R3 ram last");
    drv(32'h0204_0000, 0, 0, "R4 ram past reset size");
    // R6/R7/R11 holes
    drv(32'h01F8_0100, 0, 0, "R6 above window");
    drv(32'h01F7_FFFC, 0, 0, "R6 below window");
    drv(32'hFFFF_FFFC, 1, 0, "R6 top of space");
    drv(32'h0100_0000, 0, 0, "R7 hole addr");
    // R5 scratch storage
    drv(32'h01F8_00FC, 1, 32'hDEAD_BEEF, "R5 scratch write");
    drv(32'h01F8_0044, 1, 32'h1234_5678, "R5 scratch write 2");
    drv(32'h01F8_00FF, 0, 0, "R5 scratch readback byte addr");
    drv(32'h01F8_0044, 0, 0, "R5 scratch readback");
    drv(32'h01F8_0018, 1, 32'hA5A5_0003, "R5 wait word");
    drv(32'h01F8_0018, 0, 0, "R5 wait readback");
    // R8: config takes effect next cycle; ROM f=2 -> 16 KB, RAM f=1 -> 512 KB
    drv(32'h01F8_0010, 1, 32'h0000_0012, "R8 cfg write");
    drv(32'h0000_3FFC, 0, 0, "R8 rom f2 last");
    drv(32'h0000_4000, 0, 0, "R2 rom f2 past");
    drv(32'h0207_FFFC, 0, 0, "R4 ram f1 last");
    drv(32'h0208_0000, 0, 0, "R4 ram f1 past");
    // Saturation: fields 7 -> 512 KB ROM, 4 MB RAM
    drv(32'h01F8_0010, 1, 32'h0000_0077, "R8 cfg max");
    drv(32'h0007_FFFC, 0, 0, "R2 rom saturated last");
    drv(32'h0008_0000, 0, 0, "R2 rom saturated past");
    drv(32'h023F_FFFC, 0, 0, "R4 ram saturated last");
    drv(32'h0240_0000, 0, 0, "R4 ram saturated past");
    drv(32'h01F8_0010, 1, 32'h0000_0040, "R4 cfg ram f4");
    drv(32'h023F_FFFC, 0, 0, "R4 ram f4 last");
    drv(32'h01F8_0010, 1, 32'h0000_0000, "R8 cfg back to reset size");
    // R9 protection
    drv(32'h01F8_0020, 1, 32'h001F_0010, "R9 win0");
    drv(32'h01F8_0024, 1, 32'h0100_0100, "R9 win1");
    drv(32'h0200_2000, 1, 0, "R9 off no trap");
    drv(32'h01F8_0000, 1, 32'h0000_0008, "R9 enable");
    drv(32'h0200_1000, 1, 0, "R9 win0 low bound");
    drv(32'h0200_1FFC, 1, 0, "R9 win0 high bound");
    drv(32'h0200_0FFC, 1, 0, "R9 below win0");
    drv(32'h0200_2000, 1, 0, "R9 above win0");
    drv(32'h0201_0000, 1, 0, "R9 win1");
    drv(32'h0201_0100, 1, 0, "R9 past win1");
    drv(32'h0200_2000, 0, 0, "R9 read unguarded");
    drv(32'h0000_0010, 1, 0, "R9 rom write not guarded");
    drv(32'h01F8_0000, 1, 32'h0000_0000, "R9 disable");
    drv(32'h0200_2000, 1, 0, "R9 disabled no trap");
    // R8/R11: idle strobe produces no select
    idle();
    #4;
    checks++;
    if ({sel_rom, sel_ram, sel_reg, acc_err} !== 4'b0) begin
      failures++;
      $display("FAIL R11 idle: got %b%b%b%b expected 0000", sel_rom, sel_ram, sel_reg, acc_err);
    end
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      failures++; checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    finish_run();
  end
endmodule